// File: doc/BRIEF.md
# Prescaled Serial Bit-Rate Tick Generator

This block produces the frame-timing strobe for a serial port from the peripheral clock. A two-bit prescale select picks a divide-by of 1, 4, 16 or 64. An 8-bit rate value N is then multiplied by a fixed oversampling factor of 32. Each time 32 × prescale × (N+1) clock cycles have elapsed, the block emits a tick that is one cycle wide. Line sampling and shifting are done elsewhere, driven by this tick.

The block also holds the serial mode byte and the serial control byte so that software can read them back. Each is stored with only its defined bits. Control bit 1 selects an external clock source. While it is set, the internal divider stays at zero and issues no ticks. A write that changes the divisor restarts the count from zero, so a shortened period never appears.

All registers are written through a one-cycle write strobe with a 2-bit select. The written value is visible on the read-back outputs on the cycle after the write edge.

Top module: `baud_tick_gen`

## Requirements
- R1: A synchronous reset (rst high) clears the mode byte and control byte to 0, sets the rate byte to 0xFF and holds tick low. The first tick rises 8192 clock edges after the last reset edge.
- R2: When wr_en is high at a rising edge, wr_sel chooses the register: 0 = mode, 1 = rate, 2 = control, 3 = none. The new value is visible from that edge on.
- R3: The mode byte stores only bits 6, 5, 4, 3, 1 and 0 of the written value (mask 0x7B); the other bits read 0. Bit 6 selects 7-bit data, bit 5 enables parity, bit 4 selects odd parity and bit 3 selects two stop bits.
- R4: The control byte stores only bits 7, 6, 5, 4, 3 and 1 (mask 0xFA). Bit 7 is the transmit interrupt enable, bit 6 the receive interrupt enable, bit 5 transmit enable, bit 4 receive enable, bit 3 the error interrupt enable and bit 1 the external clock select.
- R5: Mode bits 1:0 select the prescale: 0 → 1, 1 → 4, 2 → 16, 3 → 64.
- R6: Between consecutive ticks there are exactly 32 × prescale × (rate + 1) clock edges, and tick is high for a single cycle.
- R7: Any write to the rate register, even with an unchanged value, restarts the divider. No tick rises at that write edge, and the next tick rises exactly one new period of edges after it.
- R8: A mode write that changes bits 1:0 restarts the divider in the same way as R7. A mode write that leaves bits 1:0 unchanged does not disturb tick timing.
- R9: While control bit 1 is set, no tick is produced and the divider is held at zero. The first tick after it is cleared rises one full period of edges after the clearing edge.
- R10: A write with wr_sel = 3 changes no register and does not restart the divider.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 mode, 1 rate, 2 control, 3 none |
| wr_data | input | 8 | Write data |
| mode_q | output | 8 | Stored mode byte |
| rate_q | output | 8 | Stored rate byte |
| ctrl_q | output | 8 | Stored control byte |
| tick | output | 1 | One-cycle strobe at the end of each period |

## Verification
Two events can fall on the same rising edge: the divider reaching its terminal count, and a register write that restarts it. Two variants provoke this. In the first, the bench's reference model reports that the next edge would raise tick, and the bench times a rate write to that edge. In the second, it times a prescale-changing mode write to that edge. The restart must win in both: tick stays low, and the following tick lands one full new period after the write. The behavioural model is compared on every cycle, so this is judged without timing tables.

// File: rtl/baud_pkg.sv
package baud_pkg;
   localparam int DATA_W = 8;

   typedef enum logic [1:0] {
      SEL_MODE = 2'd0,
      SEL_RATE = 2'd1,
      SEL_CTRL = 2'd2,
      SEL_NONE = 2'd3
   } reg_sel_e;

   localparam logic [DATA_W-1:0] MODE_KEEP = 8'h7B;
   localparam logic [DATA_W-1:0] CTRL_KEEP = 8'hFA;
   localparam int                EXT_CLK_BIT = 1;
   localparam int                PSEL_W = 2;
endpackage

// File: rtl/btg_regs.sv
module btg_regs
   import baud_pkg::*;
#(
   parameter int RATE_W = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_en,
   input  logic [1:0]        wr_sel,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] mode_q,
   output logic [RATE_W-1:0] rate_q,
   output logic [DATA_W-1:0] ctrl_q,
   output logic              restart
);
   localparam logic [RATE_W-1:0] RATE_INIT = {RATE_W{1'b1}};

   logic psel_change;

   // a divisor change: any rate write, or a prescale-select change
   assign psel_change = (wr_data[PSEL_W-1:0] != mode_q[PSEL_W-1:0]);
   assign restart = wr_en &&
                    ((wr_sel == SEL_RATE) || ((wr_sel == SEL_MODE) && psel_change));

   always_ff @(posedge clk) begin
      if (rst) begin
         mode_q <= '0;
         rate_q <= RATE_INIT;
         ctrl_q <= '0;
      end else if (wr_en) begin
         case (wr_sel)
            SEL_MODE: mode_q <= wr_data & MODE_KEEP;
            SEL_RATE: rate_q <= wr_data[RATE_W-1:0];
            SEL_CTRL: ctrl_q <= wr_data & CTRL_KEEP;
            default:  ;
         endcase
      end
   end
endmodule

// File: rtl/btg_prescale.sv
module btg_prescale #(
   parameter int SEL_W     = 2,
   parameter int STEP_LOG2 = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             clr,
   input  logic [SEL_W-1:0] sel,
   output logic             strobe
);
   localparam int MAX_SHIFT = STEP_LOG2 * ((1 << SEL_W) - 1);
   localparam int CNT_W     = (MAX_SHIFT > 0) ? MAX_SHIFT : 1;

   generate
      if (MAX_SHIFT == 0) begin : g_bypass
         assign strobe = !clr;
      end else begin : g_count
         logic [CNT_W-1:0] pcnt;
         logic [CNT_W:0]   span;
         logic [CNT_W-1:0] limit;

         always_comb begin
            span  = (CNT_W+1)'(1) << (int'(sel) * STEP_LOG2);
            limit = CNT_W'(span - 1'b1);
         end

         assign strobe = !clr && (pcnt == limit);

         always_ff @(posedge clk) begin
            if (rst || clr)           pcnt <= '0;
            else if (pcnt == limit)   pcnt <= '0;
            else                      pcnt <= pcnt + 1'b1;
         end
      end
   endgenerate
endmodule

// File: rtl/btg_divider.sv
module btg_divider #(
   parameter int RATE_W  = 8,
   parameter int OS_LOG2 = 5
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              clr,
   input  logic              step,
   input  logic [RATE_W-1:0] rate,
   output logic              tick
);
   localparam int MW = RATE_W + OS_LOG2;

   logic [MW-1:0] mcnt;
   logic [MW-1:0] limit;

   // (rate + 1) * 2**OS_LOG2 - 1
   assign limit = {rate, {OS_LOG2{1'b1}}};

   always_ff @(posedge clk) begin
      if (rst || clr) begin
         mcnt <= '0;
         tick <= 1'b0;
      end else if (step) begin
         mcnt <= (mcnt == limit) ? '0 : mcnt + 1'b1;
         tick <= (mcnt == limit);
      end else begin
         tick <= 1'b0;
      end
   end
endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen
   import baud_pkg::*;
#(
   parameter int RATE_W    = 8,
   parameter int OS_LOG2   = 5,
   parameter int STEP_LOG2 = 2
) (
   input  logic        clk,
   input  logic        rst,
   input  logic        wr_en,
   input  logic [1:0]  wr_sel,
   input  logic [7:0]  wr_data,
   output logic [7:0]  mode_q,
   output logic [7:0]  rate_q,
   output logic [7:0]  ctrl_q,
   output logic        tick
);
   generate
      if (RATE_W < 1 || RATE_W > DATA_W) begin : g_bad_rate
         $error("RATE_W must lie in 1..DATA_W");
      end
      if (OS_LOG2 < 1) begin : g_bad_os
         $error("OS_LOG2 must be at least 1");
      end
      if (STEP_LOG2 < 0) begin : g_bad_step
         $error("STEP_LOG2 must not be negative");
      end
   endgenerate

   logic [RATE_W-1:0] rate_int;
   logic              restart;
   logic              clr;
   logic              pre_strobe;

   btg_regs #(.RATE_W(RATE_W)) u_regs (
      .clk     (clk),
      .rst     (rst),
      .wr_en   (wr_en),
      .wr_sel  (wr_sel),
      .wr_data (wr_data),
      .mode_q  (mode_q),
      .rate_q  (rate_int),
      .ctrl_q  (ctrl_q),
      .restart (restart)
   );

   generate
      if (RATE_W == DATA_W) begin : g_rate_full
         assign rate_q = rate_int;
      end else begin : g_rate_pad
         assign rate_q = {{(DATA_W-RATE_W){1'b0}}, rate_int};
      end
   endgenerate

   // external clock select holds the divider at zero
   assign clr = restart || ctrl_q[EXT_CLK_BIT];

   btg_prescale #(.SEL_W(PSEL_W), .STEP_LOG2(STEP_LOG2)) u_pre (
      .clk    (clk),
      .rst    (rst),
      .clr    (clr),
      .sel    (mode_q[PSEL_W-1:0]),
      .strobe (pre_strobe)
   );

   btg_divider #(.RATE_W(RATE_W), .OS_LOG2(OS_LOG2)) u_div (
      .clk  (clk),
      .rst  (rst),
      .clr  (clr),
      .step (pre_strobe),
      .rate (rate_int),
      .tick (tick)
   );
endmodule

// File: rtl/baud_tick_gen_chk.sv
module baud_tick_gen_chk #(
   parameter int OS_LOG2   = 5,
   parameter int STEP_LOG2 = 2
) (
   input logic       clk,
   input logic       rst,
   input logic       wr_en,
   input logic [1:0] wr_sel,
   input logic [7:0] wr_data,
   input logic [7:0] mode_q,
   input logic [7:0] rate_q,
   input logic [7:0] ctrl_q,
   input logic       tick
);
   logic [31:0] since_clr;
   logic [31:0] cur_period;
   logic        divisor_wr;

   assign divisor_wr = wr_en && ((wr_sel == 2'd1) ||
                       ((wr_sel == 2'd0) && (wr_data[1:0] != mode_q[1:0])));
   assign cur_period = (32'd1 << OS_LOG2) * (32'd1 << (STEP_LOG2 * int'(mode_q[1:0])))
                       * (32'(rate_q) + 32'd1);

   always_ff @(posedge clk) begin
      if (rst || divisor_wr || ctrl_q[1]) since_clr <= 32'd0;
      else if (tick)                      since_clr <= 32'd1;
      else                                since_clr <= since_clr + 32'd1;
   end

   a_r2_rate_write: assert property (@(posedge clk) disable iff (rst)
      (wr_en && wr_sel == 2'd1) |=> (rate_q == $past(wr_data)));
   a_r3_mode_mask: assert property (@(posedge clk) disable iff (rst)
      (wr_en && wr_sel == 2'd0) |=> (mode_q == ($past(wr_data) & 8'h7B)));
   a_r4_ctrl_mask: assert property (@(posedge clk) disable iff (rst)
      (wr_en && wr_sel == 2'd2) |=> (ctrl_q == ($past(wr_data) & 8'hFA)));
   a_r6_one_cycle: assert property (@(posedge clk) disable iff (rst)
      tick |=> !tick);
   a_r6_period: assert property (@(posedge clk) disable iff (rst)
      tick |-> (since_clr == cur_period));
   a_r7_restart_quiet: assert property (@(posedge clk) disable iff (rst)
      divisor_wr |=> !tick);
   a_r9_ext_hold: assert property (@(posedge clk) disable iff (rst)
      ctrl_q[1] |=> !tick);
   a_r10_none_sel: assert property (@(posedge clk) disable iff (rst)
      (wr_en && wr_sel == 2'd3) |=> ($stable(mode_q) && $stable(rate_q) && $stable(ctrl_q)));
endmodule

bind baud_tick_gen baud_tick_gen_chk #(.OS_LOG2(OS_LOG2), .STEP_LOG2(STEP_LOG2)) i_chk (
   .clk     (clk),
   .rst     (rst),
   .wr_en   (wr_en),
   .wr_sel  (wr_sel),
   .wr_data (wr_data),
   .mode_q  (mode_q),
   .rate_q  (rate_q),
   .ctrl_q  (ctrl_q),
   .tick    (tick)
);

// File: tb/test_baud_tick_gen.sv
module test_baud_tick_gen;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       wr_en = 1'b0;
   logic [1:0] wr_sel = 2'd0;
   logic [7:0] wr_data = 8'd0;
   logic [7:0] mode_q, rate_q, ctrl_q;
   logic       tick;

   int checks = 0;
   int errors = 0;
   int dut_ticks = 0;
   bit finished = 1'b0;
   string cur_req = "R1";

   // reference model state
   int m_mode = 0, m_rate = 255, m_ctrl = 0, m_cnt = 0, m_period = 8192;
   bit m_tick = 1'b0;

   always #10 clk = ~clk;

   baud_tick_gen i_baud_tick_gen (
      .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
      .mode_q(mode_q), .rate_q(rate_q), .ctrl_q(ctrl_q), .tick(tick)
   );

   function automatic int period_of(int md, int rt);
      return 32 * (1 << (2 * (md & 3))) * (rt + 1);
   endfunction

   always @(posedge clk) begin
      int per;
      bit rs;
      per = period_of(m_mode, m_rate);
      rs  = wr_en && (wr_sel == 2'd1 ||
                      (wr_sel == 2'd0 && (int'(wr_data) & 3) != (m_mode & 3)));
      if (rst) begin
         m_mode = 0; m_rate = 255; m_ctrl = 0; m_cnt = 0; m_tick = 1'b0;
      end else begin
         if (rs || m_ctrl[1]) begin
            m_cnt = 0; m_tick = 1'b0;
         end else begin
            m_cnt++;
            if (m_cnt == per) begin m_tick = 1'b1; m_cnt = 0; end
            else m_tick = 1'b0;
         end
         if (wr_en) begin
            case (wr_sel)
               2'd0: m_mode = int'(wr_data) & 8'h7B;
               2'd1: m_rate = int'(wr_data);
               2'd2: m_ctrl = int'(wr_data) & 8'hFA;
               default: ;
            endcase
         end
      end
      m_period = period_of(m_mode, m_rate);
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   // every-cycle comparison, away from the active edge
   always @(negedge clk) begin
      if (!rst && !finished) begin
         check(tick == m_tick, cur_req, int'(tick), int'(m_tick));
         check(int'(mode_q) == m_mode, "R3", int'(mode_q), m_mode);
         check(int'(rate_q) == m_rate, "R2", int'(rate_q), m_rate);
         check(int'(ctrl_q) == m_ctrl, "R4", int'(ctrl_q), m_ctrl);
         if (tick) dut_ticks++;
      end
   end

   // drive at a falling edge, hold for one rising edge
   task automatic wr(input logic [1:0] sel, input logic [7:0] d);
      wr_en = 1'b1; wr_sel = sel; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic run(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic count_window(input int n, input int exp, input string req);
      int start;
      start = dut_ticks;
      run(n);
      check(dut_ticks - start == exp, req, dut_ticks - start, exp);
   endtask

   task automatic wait_due();
      while (m_cnt != m_period - 1) @(negedge clk);
   endtask

   task automatic finish_run();
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      #(20 * 190000);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      run(3);
      rst = 1'b0;
      // R1 reset values, first tick 8192 edges after reset edge
      cur_req = "R1";
      check(mode_q == 8'h00, "R1", int'(mode_q), 0);
      check(rate_q == 8'hFF, "R1", int'(rate_q), 255);
      check(ctrl_q == 8'h00, "R1", int'(ctrl_q), 0);
      check(tick == 1'b0, "R1", int'(tick), 0);
      count_window(8200, 1, "R1");

      // R7 rate 0 at prescale 1: period 32
      cur_req = "R7";
      wr(2'd1, 8'h00);
      check(tick == 1'b0, "R7", int'(tick), 0);
      count_window(100, 3, "R6");

      // R3 / R5 / R8 mode 0xFF -> 0x7B, prescale 64, period 2048
      cur_req = "R5";
      wr(2'd0, 8'hFF);
      check(mode_q == 8'h7B, "R3", int'(mode_q), 123);
      count_window(2100, 1, "R5");

      // prescale 4, rate 1: period 256
      wr(2'd0, 8'h41);
      wr(2'd1, 8'h01);
      count_window(800, 3, "R5");

      // prescale 16, rate 0: period 512
      wr(2'd0, 8'h02);
      wr(2'd1, 8'h00);
      cur_req = "R8";
      run(200);
      wr(2'd0, 8'h0A); // same select: timing undisturbed
      count_window(600, 1, "R8");

      // R10 no-register select mid period
      cur_req = "R10";
      run(100);
      wr(2'd3, 8'hFF);
      check(mode_q == 8'h0A && ctrl_q == 8'h00, "R10", int'(mode_q), 10);
      run(600);

      // R9 external clock hold
      cur_req = "R9";
      wr(2'd2, 8'hFF);
      check(ctrl_q == 8'hFA, "R4", int'(ctrl_q), 250);
      count_window(1200, 0, "R9");
      wr(2'd2, 8'h00);
      count_window(520, 1, "R9");

      // coincidence: rate write on the would-be tick edge
      cur_req = "R7";
      wr(2'd1, 8'h00);
      wr(2'd0, 8'h00);
      wait_due();
      wr(2'd1, 8'h00);
      check(tick == 1'b0, "R7", int'(tick), 0);
      count_window(40, 1, "R7");

      // coincidence: prescale change on the would-be tick edge
      cur_req = "R8";
      wait_due();
      wr(2'd0, 8'h01);
      check(tick == 1'b0, "R8", int'(tick), 0);
      count_window(130, 1, "R8");

      // R6 a longer rate at prescale 1: 128 cycles
      cur_req = "R6";
      wr(2'd0, 8'h00);
      wr(2'd1, 8'h03);
      count_window(520, 4, "R6");

      // R1 reset mid-run restores defaults
      cur_req = "R1";
      rst = 1'b1;
      run(2);
      rst = 1'b0;
      check(rate_q == 8'hFF && mode_q == 8'h00, "R1", int'(rate_q), 255);
      run(10);
      finish_run();
   end
endmodule